// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block switches a small set of power domains between on and off, one at a time. Software writes a target state into a masked control register. Bit n of a write lands only when bit n+16 of the same word is 1. The controller then runs a fixed sequence against the domain's interconnect port and its power switch, and software polls a busy flag until the sequence ends.

Shutting a domain down first parks its interconnect port: the idle request is raised, the port acknowledges, and the port reports idle. Only then is the switch opened. Bringing a domain up reverses this order. After each switch action the controller waits a programmable settle count before it checks the switch's status input. Domains with no switch are idle-only: they follow a separate idle-request register, and their on/off state is the inverse of their idle status. Every wait stage has a cycle bound. When a bound expires, the controller leaves the sequence where it stands and sets a sticky error bit for that domain.

The sequencer uses these states: `ST_IDLE`, `ST_CHECK`, `ST_REQ_ACK`, `ST_REQ_IDLE`, `ST_SETTLE`, `ST_PWR_WAIT`, `ST_REL_ACK`, `ST_REL_IDLE`, `ST_DONE`. Its transitions are:

- `ST_IDLE` goes to `ST_CHECK` when a domain is pending, taking the lowest-numbered one.
- `ST_CHECK` goes to `ST_DONE` if the domain is already in the target state.
- For a shutdown, `ST_CHECK` goes to `ST_REQ_ACK`, which goes to `ST_REQ_IDLE` on acknowledge. `ST_REQ_IDLE` goes to `ST_SETTLE` (switch opened, down count loaded) on idle, or straight to `ST_DONE` for an idle-only domain. `ST_SETTLE` goes to `ST_PWR_WAIT`, which goes to `ST_DONE`.
- For a power-up of a switched domain, `ST_CHECK` goes to `ST_SETTLE` (switch closed, up count loaded), then to `ST_PWR_WAIT`. `ST_PWR_WAIT` goes to `ST_REL_ACK` (request dropped), then to `ST_REL_IDLE`, then to `ST_DONE`.
- For a power-up of an idle-only domain, `ST_CHECK` goes directly to `ST_REL_ACK`.
- Any wait state goes to `ST_DONE` on timeout.
- `ST_DONE` always returns to `ST_IDLE`.

Top module: `pdsc_top`

## Requirements
- R1: After reset, all domain requests are "on" (control and idle-request registers read 0), `idle_req_o` and `pwr_off_o` are 0, every settle count reads 24, the error register reads 0, and busy is 0.
- R2: A write to a control register (power control 0x00, idle request 0x04, settle counts) changes bit n only when bit n+16 of the write data is 1. Bits whose enable is 0 keep their value.
- R3: Shutdown of a switched domain follows this order:
  - raise `idle_req_o`;
  - wait for `idle_ack_i`=1, then for `idle_st_i`=1;
  - set `pwr_off_o`, wait the down count;
  - wait for `pwr_st_i`=1.
  
  `pwr_off_o` never rises while the domain's idle request is low.
- R4: Power-up of a switched domain follows this order:
  - clear `pwr_off_o`, wait the up count;
  - wait for `pwr_st_i`=0;
  - drop `idle_req_o`;
  - wait for `idle_ack_i`=0, then for `idle_st_i`=0.
  
  The idle request never falls while power is absent.
- R5: The status register (0x08) bit n reads 1 for "off": for a switched domain it is `pwr_st_i`, for an idle-only domain it is `idle_st_i`. Register 0x0C shows `idle_ack_i` in bits [N-1:0] and `idle_st_i` in bits [16+N-1:16].
- R6: An idle-only domain (`PWR_MASK` bit 0; domain 3 by default) is driven from register 0x04 bit n (1 = idle/off) and never drives `pwr_off_o`. Power-control writes to it start nothing, and idle-request writes to switched domains start nothing.
- R7: The shutdown settle count of domain d is at 0x40+8d and the power-up count at 0x44+8d. A count larger by k lengthens the sequence by exactly k cycles.
- R8: A wait for acknowledge, idle or power status that lasts `TMO_CYC` (10000) cycles ends the sequence. It sets error bit d and makes no further output change; in particular a failed shutdown handshake leaves power on.
- R9: Error bits (0x10) are sticky. Writing 1 to bit n clears it, and a new error in the same cycle takes precedence.
- R10: Only one domain is sequenced at a time. When several are pending, the lowest index goes first. No cycle changes outputs of more than one domain.
- R11: A request for a domain already in the requested state ends within a few cycles, with no change on any output.
- R12: Busy (port, and 0x14 bit 0) is 1 from the cycle after a request write until the sequence ends. Outputs change only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid in the same cycle |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data; upper half is the per-bit write enable |
| bus_rdata | output | 32 | Read data (0 when `bus_rd` is low) |
| busy | output | 1 | A transition is pending or running |
| idle_req_o | output | N_DOM | Idle request to each domain's interconnect port |
| idle_ack_i | input | N_DOM | Idle acknowledge from each port |
| idle_st_i | input | N_DOM | Idle status from each port |
| pwr_off_o | output | N_DOM | Power switch control, 1 = open |
| pwr_st_i | input | N_DOM | Switch status, 1 = domain unpowered |

## Verification
The hardest situations to reach from the ports are the expired waits. A port that never acknowledges, or a switch that never reports, only shows up after ten thousand cycles. Recovery from either leaves the domain half-sequenced. The bench's handshake and switch models have per-domain stuck controls: it holds one stuck through a full timeout, releases it, and then requests the opposite state, so that the restart path out of `ST_CHECK` is driven. The settle counts are checked by comparing two shutdowns that differ only in the programmed count.

// File: rtl/pdsc_pkg.sv
package pdsc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_REQ_ACK,
        ST_REQ_IDLE,
        ST_SETTLE,
        ST_PWR_WAIT,
        ST_REL_ACK,
        ST_REL_IDLE,
        ST_DONE
    } seq_state_t;

    localparam logic [7:0] A_PWR_CTRL = 8'h00;
    localparam logic [7:0] A_IDLE_REQ = 8'h04;
    localparam logic [7:0] A_STATUS   = 8'h08;
    localparam logic [7:0] A_HSHAKE   = 8'h0C;
    localparam logic [7:0] A_ERR      = 8'h10;
    localparam logic [7:0] A_BUSY     = 8'h14;
    localparam logic [7:0] A_CNT_BASE = 8'h40;

    // Bit-enabled update: enable in upper half, value in lower half.
    function automatic logic [15:0] mwr(input logic [15:0] old, input logic [31:0] w);
        return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
    endfunction

endpackage

// File: rtl/pdsc_tmo.sv
module pdsc_tmo #(
    parameter int LIM = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);
    localparam int CW = $clog2(LIM + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !run) begin
            cnt <= '0;
        end else if (cnt != CW'(LIM - 1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == CW'(LIM - 1));

endmodule

// File: rtl/pdsc_regs.sv
module pdsc_regs import pdsc_pkg::*; #(
    parameter int          N_DOM    = 4,
    parameter logic [15:0] PWR_MASK = 16'h0007,
    parameter int          CNT_W    = 16,
    parameter int          CNT_RST  = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [7:0]             bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [N_DOM-1:0]       pend_clr,
    input  logic [N_DOM-1:0]       err_set,
    input  logic                   active,
    input  logic [N_DOM-1:0]       ack_i,
    input  logic [N_DOM-1:0]       idle_i,
    input  logic [N_DOM-1:0]       pwr_i,
    output logic [N_DOM-1:0]       tgt,
    output logic [N_DOM-1:0]       pend,
    output logic [N_DOM*CNT_W-1:0] dn_flat,
    output logic [N_DOM*CNT_W-1:0] up_flat,
    output logic                   busy
);
    localparam logic [N_DOM-1:0] SW_MASK = PWR_MASK[N_DOM-1:0];

    logic [N_DOM-1:0] ctrl_q, isw_q, err_q;
    logic [N_DOM-1:0] new_pend;
    logic [CNT_W-1:0] dn_q [N_DOM];
    logic [CNT_W-1:0] up_q [N_DOM];
    logic             wr_ctrl, wr_isw, wr_err;

    assign wr_ctrl = bus_wr && (bus_addr == A_PWR_CTRL);
    assign wr_isw  = bus_wr && (bus_addr == A_IDLE_REQ);
    assign wr_err  = bus_wr && (bus_addr == A_ERR);

    always_comb begin
        new_pend = '0;
        if (wr_ctrl) new_pend = new_pend | (bus_wdata[16 +: N_DOM] & SW_MASK);
        if (wr_isw)  new_pend = new_pend | (bus_wdata[16 +: N_DOM] & ~SW_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            isw_q  <= '0;
            err_q  <= '0;
            pend   <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= N_DOM'(mwr(16'(ctrl_q), bus_wdata));
            if (wr_isw)  isw_q  <= N_DOM'(mwr(16'(isw_q), bus_wdata));
            err_q <= (wr_err ? (err_q & ~bus_wdata[N_DOM-1:0]) : err_q) | err_set;
            pend  <= (pend & ~pend_clr) | new_pend;
        end
    end

    for (genvar d = 0; d < N_DOM; d++) begin : g_cnt
        localparam logic [7:0] A_DN = 8'(A_CNT_BASE + 8 * d);
        localparam logic [7:0] A_UP = 8'(A_CNT_BASE + 8 * d + 4);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dn_q[d] <= CNT_W'(CNT_RST);
                up_q[d] <= CNT_W'(CNT_RST);
            end else if (bus_wr) begin
                if (bus_addr == A_DN) dn_q[d] <= CNT_W'(mwr(16'(dn_q[d]), bus_wdata));
                if (bus_addr == A_UP) up_q[d] <= CNT_W'(mwr(16'(up_q[d]), bus_wdata));
            end
        end

        assign dn_flat[d*CNT_W +: CNT_W] = dn_q[d];
        assign up_flat[d*CNT_W +: CNT_W] = up_q[d];
        assign tgt[d] = SW_MASK[d] ? ctrl_q[d] : isw_q[d];
    end

    assign busy = active || (|pend);

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_PWR_CTRL: bus_rdata[N_DOM-1:0] = ctrl_q;
                A_IDLE_REQ: bus_rdata[N_DOM-1:0] = isw_q;
                A_STATUS:   bus_rdata[N_DOM-1:0] = (pwr_i & SW_MASK) | (idle_i & ~SW_MASK);
                A_HSHAKE: begin
                    bus_rdata[N_DOM-1:0]   = ack_i;
                    bus_rdata[16 +: N_DOM] = idle_i;
                end
                A_ERR:      bus_rdata[N_DOM-1:0] = err_q;
                A_BUSY:     bus_rdata[0] = busy;
                default: begin
                    for (int d = 0; d < N_DOM; d++) begin
                        if (bus_addr == 8'(A_CNT_BASE + 8 * d))     bus_rdata[CNT_W-1:0] = dn_q[d];
                        if (bus_addr == 8'(A_CNT_BASE + 8 * d + 4)) bus_rdata[CNT_W-1:0] = up_q[d];
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/pdsc_seq.sv
module pdsc_seq import pdsc_pkg::*; #(
    parameter int          N_DOM    = 4,
    parameter logic [15:0] PWR_MASK = 16'h0007,
    parameter int          CNT_W    = 16,
    parameter int          TMO_CYC  = 10000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_DOM-1:0]       pend,
    input  logic [N_DOM-1:0]       tgt,
    input  logic [N_DOM*CNT_W-1:0] dn_flat,
    input  logic [N_DOM*CNT_W-1:0] up_flat,
    input  logic [N_DOM-1:0]       ack_i,
    input  logic [N_DOM-1:0]       idle_i,
    input  logic [N_DOM-1:0]       pwr_i,
    output logic [N_DOM-1:0]       req_o,
    output logic [N_DOM-1:0]       off_o,
    output logic [N_DOM-1:0]       pend_clr,
    output logic [N_DOM-1:0]       err_set,
    output logic                   active
);
    localparam int DW = (N_DOM > 1) ? $clog2(N_DOM) : 1;

    seq_state_t       state, nxt;
    logic [DW-1:0]    cur, pick_idx;
    logic             dir_off;
    logic [CNT_W-1:0] settle;
    logic             has_pwr, s_ack, s_idle, s_pwr, stat, already;
    logic             in_wait, tmo, restart;
    logic             pick, fail, a_set_req, a_clr_req, a_set_off, a_clr_off;
    logic             a_load_dn, a_load_up;

    // lowest pending index wins
    always_comb begin
        pick_idx = '0;
        for (int d = N_DOM - 1; d >= 0; d--) begin
            if (pend[d]) pick_idx = DW'(d);
        end
    end

    assign has_pwr = PWR_MASK[cur];
    assign s_ack   = ack_i[cur];
    assign s_idle  = idle_i[cur];
    assign s_pwr   = pwr_i[cur];
    assign stat    = has_pwr ? s_pwr : s_idle;
    assign already = dir_off ? (stat && req_o[cur]) : (!stat && !req_o[cur]);

    assign in_wait = (state == ST_REQ_ACK) || (state == ST_REQ_IDLE) ||
                     (state == ST_PWR_WAIT) || (state == ST_REL_ACK) ||
                     (state == ST_REL_IDLE);
    assign restart = (nxt != state);

    pdsc_tmo #(.LIM(TMO_CYC)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_wait),
        .restart (restart),
        .expired (tmo)
    );

    // next state and step actions
    always_comb begin
        nxt       = state;
        pick      = 1'b0;
        fail      = 1'b0;
        a_set_req = 1'b0;
        a_clr_req = 1'b0;
        a_set_off = 1'b0;
        a_clr_off = 1'b0;
        a_load_dn = 1'b0;
        a_load_up = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (|pend) begin
                    nxt  = ST_CHECK;
                    pick = 1'b1;
                end
            end
            ST_CHECK: begin
                if (already) begin
                    nxt = ST_DONE;
                end else if (dir_off) begin
                    nxt       = ST_REQ_ACK;
                    a_set_req = 1'b1;
                end else if (has_pwr) begin
                    nxt       = ST_SETTLE;
                    a_clr_off = 1'b1;
                    a_load_up = 1'b1;
                end else begin
                    nxt       = ST_REL_ACK;
                    a_clr_req = 1'b1;
                end
            end
            ST_REQ_ACK: begin
                if (s_ack) begin
                    nxt = ST_REQ_IDLE;
                end else if (tmo) begin
                    nxt  = ST_DONE;
                    fail = 1'b1;
                end
            end
            ST_REQ_IDLE: begin
                if (s_idle) begin
                    if (has_pwr) begin
                        nxt       = ST_SETTLE;
                        a_set_off = 1'b1;
                        a_load_dn = 1'b1;
                    end else begin
                        nxt = ST_DONE;
                    end
                end else if (tmo) begin
                    nxt  = ST_DONE;
                    fail = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (settle == '0) nxt = ST_PWR_WAIT;
            end
            ST_PWR_WAIT: begin
                if (s_pwr == dir_off) begin
                    if (dir_off) begin
                        nxt = ST_DONE;
                    end else begin
                        nxt       = ST_REL_ACK;
                        a_clr_req = 1'b1;
                    end
                end else if (tmo) begin
                    nxt  = ST_DONE;
                    fail = 1'b1;
                end
            end
            ST_REL_ACK: begin
                if (!s_ack) begin
                    nxt = ST_REL_IDLE;
                end else if (tmo) begin
                    nxt  = ST_DONE;
                    fail = 1'b1;
                end
            end
            ST_REL_IDLE: begin
                if (!s_idle) begin
                    nxt = ST_DONE;
                end else if (tmo) begin
                    nxt  = ST_DONE;
                    fail = 1'b1;
                end
            end
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur     <= '0;
            dir_off <= 1'b0;
            settle  <= '0;
            req_o   <= '0;
            off_o   <= '0;
        end else begin
            if (pick) begin
                cur     <= pick_idx;
                dir_off <= tgt[pick_idx];
            end
            if (a_set_req) req_o[cur] <= 1'b1;
            if (a_clr_req) req_o[cur] <= 1'b0;
            if (a_set_off) off_o[cur] <= 1'b1;
            if (a_clr_off) off_o[cur] <= 1'b0;
            if (a_load_dn) begin
                settle <= dn_flat[cur*CNT_W +: CNT_W];
            end else if (a_load_up) begin
                settle <= up_flat[cur*CNT_W +: CNT_W];
            end else if (state == ST_SETTLE && settle != '0) begin
                settle <= settle - 1'b1;
            end
        end
    end

    assign pend_clr = pick ? (N_DOM'(1) << pick_idx) : '0;
    assign err_set  = fail ? (N_DOM'(1) << cur) : '0;
    assign active   = (state != ST_IDLE);

endmodule

// File: rtl/pdsc_top.sv
module pdsc_top import pdsc_pkg::*; #(
    parameter int          N_DOM    = 4,
    parameter logic [15:0] PWR_MASK = 16'h0007,
    parameter int          CNT_W    = 16,
    parameter int          CNT_RST  = 24,
    parameter int          TMO_CYC  = 10000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             busy,
    output logic [N_DOM-1:0] idle_req_o,
    input  logic [N_DOM-1:0] idle_ack_i,
    input  logic [N_DOM-1:0] idle_st_i,
    output logic [N_DOM-1:0] pwr_off_o,
    input  logic [N_DOM-1:0] pwr_st_i
);
    logic [N_DOM-1:0]       tgt, pend, pend_clr, err_set;
    logic [N_DOM*CNT_W-1:0] dn_flat, up_flat;
    logic                   active;

    pdsc_regs #(
        .N_DOM(N_DOM), .PWR_MASK(PWR_MASK), .CNT_W(CNT_W), .CNT_RST(CNT_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pend_clr  (pend_clr),
        .err_set   (err_set),
        .active    (active),
        .ack_i     (idle_ack_i),
        .idle_i    (idle_st_i),
        .pwr_i     (pwr_st_i),
        .tgt       (tgt),
        .pend      (pend),
        .dn_flat   (dn_flat),
        .up_flat   (up_flat),
        .busy      (busy)
    );

    pdsc_seq #(
        .N_DOM(N_DOM), .PWR_MASK(PWR_MASK), .CNT_W(CNT_W), .TMO_CYC(TMO_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend),
        .tgt      (tgt),
        .dn_flat  (dn_flat),
        .up_flat  (up_flat),
        .ack_i    (idle_ack_i),
        .idle_i   (idle_st_i),
        .pwr_i    (pwr_st_i),
        .req_o    (idle_req_o),
        .off_o    (pwr_off_o),
        .pend_clr (pend_clr),
        .err_set  (err_set),
        .active   (active)
    );

endmodule

// File: rtl/pdsc_chk.sv
module pdsc_chk #(
    parameter int          N_DOM    = 4,
    parameter logic [15:0] PWR_MASK = 16'h0007
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic [N_DOM-1:0] idle_req_o,
    input logic [N_DOM-1:0] pwr_off_o,
    input logic [N_DOM-1:0] pwr_st_i
);
    // R3
    off_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_off_o & ~$past(pwr_off_o)) & ~idle_req_o) == '0);

    // R4
    rel_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((idle_req_o ^ $past(idle_req_o)) & ~idle_req_o & PWR_MASK[N_DOM-1:0]
         & ($past(pwr_st_i) | $past(pwr_off_o))) == '0);

    // R10
    one_domain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones((idle_req_o ^ $past(idle_req_o)) | (pwr_off_o ^ $past(pwr_off_o))) <= 1);

    // R12
    change_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((idle_req_o != $past(idle_req_o)) || (pwr_off_o != $past(pwr_off_o))) |-> $past(busy));

    // R6
    idle_only_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|(pwr_off_o & ~PWR_MASK[N_DOM-1:0])) |-> 1'b0);

endmodule

bind pdsc_top pdsc_chk #(.N_DOM(N_DOM), .PWR_MASK(PWR_MASK)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .idle_req_o (idle_req_o),
    .pwr_off_o  (pwr_off_o),
    .pwr_st_i   (pwr_st_i)
);

// File: tb/tb_pdsc_top.sv
module tb_pdsc_top;
    localparam int CLK_P = 10;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         busy;
    logic [N-1:0] idle_req_o, pwr_off_o;
    logic [N-1:0] ack_m, idle_m, pwr_m;
    logic [N-1:0] stuck_ack = '0, stuck_pwr = '0;
    int           ack_cnt [N];
    int           pwr_cnt [N];

    int checks = 0;
    int errors = 0;
    logic [5:0] exp_q [$];
    logic [N-1:0] prev_req, prev_off;

    always #(CLK_P/2) clk = ~clk;

    pdsc_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .busy       (busy),
        .idle_req_o (idle_req_o),
        .idle_ack_i (ack_m),
        .idle_st_i  (idle_m),
        .pwr_off_o  (pwr_off_o),
        .pwr_st_i   (pwr_m)
    );

    // interconnect port and power switch models
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_m <= '0; idle_m <= '0; pwr_m <= '0;
            for (int d = 0; d < N; d++) begin ack_cnt[d] <= 0; pwr_cnt[d] <= 0; end
        end else begin
            for (int d = 0; d < N; d++) begin
                if (idle_req_o[d] != ack_m[d]) begin
                    if (ack_cnt[d] >= 2) begin
                        if (!(stuck_ack[d] && idle_req_o[d])) ack_m[d] <= idle_req_o[d];
                        ack_cnt[d] <= 0;
                    end else ack_cnt[d] <= ack_cnt[d] + 1;
                end else ack_cnt[d] <= 0;
                if (idle_m[d] != ack_m[d]) idle_m[d] <= ack_m[d];
                if (pwr_off_o[d] != pwr_m[d]) begin
                    if (pwr_cnt[d] >= 3) begin
                        if (!(stuck_pwr[d] && pwr_off_o[d])) pwr_m[d] <= pwr_off_o[d];
                        pwr_cnt[d] <= 0;
                    end else pwr_cnt[d] <= pwr_cnt[d] + 1;
                end else pwr_cnt[d] <= 0;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard: kind 0 = idle request, 1 = power off
    task automatic expect_ev(input logic kind, input int dom, input logic val);
        exp_q.push_back({kind, 4'(dom), val});
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_req <= '0; prev_off <= '0;
        end else begin
            for (int d = 0; d < N; d++) begin
                if (idle_req_o[d] != prev_req[d]) begin
                    if (exp_q.size() == 0) check("R3/R4 unexpected req edge", {1'b0, 4'(d), idle_req_o[d]}, 32'h3f);
                    else check("R3/R4/R10 event order", {1'b0, 4'(d), idle_req_o[d]}, exp_q.pop_front());
                end
                if (pwr_off_o[d] != prev_off[d]) begin
                    if (exp_q.size() == 0) check("R3/R4 unexpected pwr edge", {1'b1, 4'(d), pwr_off_o[d]}, 32'h3f);
                    else check("R3/R4/R10 event order", {1'b1, 4'(d), pwr_off_o[d]}, exp_q.pop_front());
                end
            end
            prev_req <= idle_req_o;
            prev_off <= pwr_off_o;
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check(tag, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (busy && cyc < 30000) begin
            @(negedge clk);
            cyc++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic drained(input string tag);
        check(tag, exp_q.size(), 0);
    endtask

    initial begin
        int dur, dur1, dur2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 pwr ctrl", 8'h00, 0);
        rd_chk("R1 status", 8'h08, 0);
        rd_chk("R1 err", 8'h10, 0);
        rd_chk("R1 busy", 8'h14, 0);
        rd_chk("R1 down count", 8'h40, 24);
        rd_chk("R1 up count", 8'h5C, 24);
        check("R1 outputs", {idle_req_o, pwr_off_o}, 0);

        // R2 masked write: only bit0 enabled, R3 shutdown order
        expect_ev(0, 0, 1); expect_ev(1, 0, 1);
        bus_write(8'h00, 32'h0001_0003);
        rd_chk("R12 busy reg", 8'h14, 1);
        wait_done(dur);
        rd_chk("R2 masked ctrl", 8'h00, 32'h1);
        rd_chk("R5 status off", 8'h08, 32'h1);
        rd_chk("R5 handshake reg", 8'h0C, 32'h0001_0001);
        drained("R3 drained");

        // R4 power-up order
        expect_ev(1, 0, 0); expect_ev(0, 0, 0);
        bus_write(8'h00, 32'h0001_0000);
        wait_done(dur);
        rd_chk("R4 status on", 8'h08, 0);
        drained("R4 drained");

        // R10 two domains, lowest first
        expect_ev(0, 1, 1); expect_ev(1, 1, 1); expect_ev(0, 2, 1); expect_ev(1, 2, 1);
        bus_write(8'h00, 32'h0006_0006);
        wait_done(dur);
        rd_chk("R10 both off", 8'h08, 32'h6);
        expect_ev(1, 1, 0); expect_ev(0, 1, 0); expect_ev(1, 2, 0); expect_ev(0, 2, 0);
        bus_write(8'h00, 32'h0006_0000);
        wait_done(dur);
        drained("R10 drained");

        // R6 idle-only domain 3
        expect_ev(0, 3, 1);
        bus_write(8'h04, 32'h0008_0008);
        wait_done(dur);
        rd_chk("R6 R5 idle-only status", 8'h08, 32'h8);
        check("R6 no power on idle-only", pwr_off_o, 0);
        expect_ev(0, 3, 0);
        bus_write(8'h04, 32'h0008_0000);
        wait_done(dur);
        rd_chk("R6 idle-only back on", 8'h08, 0);
        bus_write(8'h00, 32'h0008_0008);
        wait_done(dur);
        check("R6 ctrl write ignored for idle-only", {idle_req_o, pwr_off_o}, 0);
        bus_write(8'h04, 32'h0001_0001);
        wait_done(dur);
        check("R6 idle write ignored for switched", {idle_req_o, pwr_off_o}, 0);
        bus_write(8'h00, 32'h0008_0000);
        bus_write(8'h04, 32'h0001_0000);
        drained("R6 drained");

        // R11 already on
        bus_write(8'h00, 32'h0001_0000);
        wait_done(dur);
        check("R11 immediate completion", dur <= 4, 1);
        drained("R11 no events");

        // R2 masked count write, R7 settle length
        bus_write(8'h48, 32'h00FF_0033);
        rd_chk("R2 masked count", 8'h48, 32'h33);
        bus_write(8'h48, 32'hFFFF_000A);
        expect_ev(0, 1, 1); expect_ev(1, 1, 1);
        bus_write(8'h00, 32'h0002_0002);
        wait_done(dur1);
        expect_ev(1, 1, 0); expect_ev(0, 1, 0);
        bus_write(8'h00, 32'h0002_0000);
        wait_done(dur);
        bus_write(8'h48, 32'hFFFF_0041);
        expect_ev(0, 1, 1); expect_ev(1, 1, 1);
        bus_write(8'h00, 32'h0002_0002);
        wait_done(dur2);
        check("R7 settle difference", dur2 - dur1, 55);
        expect_ev(1, 1, 0); expect_ev(0, 1, 0);
        bus_write(8'h00, 32'h0002_0000);
        wait_done(dur);
        drained("R7 drained");

        // R8 acknowledge timeout
        stuck_ack[2] = 1'b1;
        expect_ev(0, 2, 1);
        bus_write(8'h00, 32'h0004_0004);
        wait_done(dur);
        check("R8 wait length", dur >= 10000, 1);
        rd_chk("R8 err bit", 8'h10, 32'h4);
        check("R8 power kept", pwr_off_o, 0);
        rd_chk("R8 status still on", 8'h08, 0);
        bus_write(8'h10, 32'h4);
        rd_chk("R9 w1c", 8'h10, 0);
        stuck_ack[2] = 1'b0;
        repeat (10) @(negedge clk);
        expect_ev(0, 2, 0);
        bus_write(8'h00, 32'h0004_0000);
        wait_done(dur);
        rd_chk("R8 recovered no err", 8'h10, 0);
        drained("R8 drained");

        // R8 power status timeout
        stuck_pwr[1] = 1'b1;
        expect_ev(0, 1, 1); expect_ev(1, 1, 1);
        bus_write(8'h00, 32'h0002_0002);
        wait_done(dur);
        rd_chk("R8 power wait err", 8'h10, 32'h2);
        bus_write(8'h10, 32'h1);
        rd_chk("R9 other bit kept", 8'h10, 32'h2);
        stuck_pwr[1] = 1'b0;
        repeat (10) @(negedge clk);
        expect_ev(1, 1, 0); expect_ev(0, 1, 0);
        bus_write(8'h00, 32'h0002_0000);
        wait_done(dur);
        rd_chk("R4 recovered status", 8'h08, 0);
        drained("R8 power drained");
        rd_chk("R12 idle busy", 8'h14, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule